// File: doc/BRIEF.md
# Remote Reconfiguration Command Sequencer

This block drives the register port of an on-chip configuration unit that can reload the device from one of two stored images. A user asks for one of two commands over a plain request/done handshake. A reconfiguration command can first write an image choice that overrides the external select pin and wait for the unit to go idle. It then writes the trigger and keeps the register bus completely quiet for a configurable number of cycles. A capture command tells the unit to latch one of four internal registers, then waits for the unit's busy flag to clear.

Each state of the sequencer is one clock cycle on the register bus. Every write is split into a setup cycle and a strobe cycle. Address and data stay the same in both cycles, and the write strobe is raised only in the second. The quiet window after the trigger write exists because a further access that comes too soon can cancel a reconfiguration that is already under way. The busy flag is not consulted after the trigger, because the unit does not raise it for that write. A command is one-shot: requests that arrive while a command is running are dropped.

Top module: `recfg_cmd_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle within one clock. From the next cycle, address, write data, write and read are all zero, and so are the done and error outputs.
- R2: A reconfiguration request with override enabled starts with a write at address 1. The write data has bit 0 = 1 (override of the select pin) and bit 1 = the requested image, all other bits 0. It takes a setup cycle with write low, then a strobe cycle with write high, and is followed by a busy poll (R3).
- R3: A busy poll drives address 3 with read high for one request cycle. It then keeps read high at address 3 in a sampling state until bit 0 of the read data is seen as 0. The number of sampling cycles is max(1, number of busy cycles remaining).
- R4: The reconfiguration trigger is a write of data 1 at address 0, in setup and strobe form. Without override it is the first access of a reconfiguration command. With override it follows the busy poll.
- R5: After the trigger strobe, all bus outputs stay zero for exactly GAP_CYCLES cycles, with no busy poll. The command then completes. A GAP_CYCLES value below 2 is raised to 2.
- R6: A capture request with register index k (0 to 3) writes data with only bit k set at address 2, in setup and strobe form. It then runs a busy poll (R3) and completes.
- R7: Completion is signalled by cmd_done high for exactly one cycle, the first idle cycle after the command's last bus cycle.
- R8: Requests are taken only in idle. If both requests are high in the same cycle, reconfiguration wins. Requests raised while a command runs are ignored and leave the bus sequence unchanged.
- R9: If bit 0 of the read data is still 1 after TIMEOUT_CYCLES consecutive sampling cycles, the command is abandoned. cmd_done and cmd_error are then both high for one cycle, and cmd_error is never high without cmd_done.
- R10: Write and read are never high together. Every write strobe cycle is preceded by a cycle with the same address and data and write low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the configuration unit |
| rst | input | 1 | Synchronous active-high reset |
| req_reconfig | input | 1 | Request a reconfiguration command |
| req_image | input | 1 | Image to select when override is enabled |
| req_override | input | 1 | Write the image choice over the select pin first |
| req_capture | input | 1 | Request a register capture command |
| req_reg_sel | input | 2 | Index of the register to capture |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_error | output | 1 | One-cycle poll timeout flag, paired with cmd_done |
| reg_addr | output | 3 | Register bus address |
| reg_write | output | 1 | Register bus write strobe |
| reg_read | output | 1 | Register bus read request |
| reg_wdata | output | DATA_W | Register bus write data |
| reg_rdata | input | DATA_W | Register bus read data, bit 0 is the busy flag |

## Verification
The main instance is built with GAP_CYCLES=4, TIMEOUT_CYCLES=6 and DATA_W=8. With these values the quiet window, the timeout and every one-hot capture bit fit in short traces. This makes it practical to sweep every image, override and register index against busy lengths 0 to 3, which covers the max(1, n) sampling rule. A second instance is built with GAP_CYCLES=1 and fed the same requests, so that the raise of an illegal gap to 2 shows up directly in when its done pulse arrives. A busy length larger than the timeout brings the error path within reach for both commands.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_TRIGGER = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IMAGE   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CAPTURE = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 3'd3;

    localparam int SEL_OVR_BIT = 0;
    localparam int SEL_IMG_BIT = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL_SET,
        ST_SEL_STB,
        ST_POLL_REQ,
        ST_POLL_SMP,
        ST_TRG_SET,
        ST_TRG_STB,
        ST_QUIET,
        ST_CAP_SET,
        ST_CAP_STB
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_RECFG,
        CMD_CAPTURE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic       image;
        logic [1:0] reg_sel;
    } seq_cmd_t;

endpackage

// File: rtl/recfg_tick_cnt.sv
module recfg_tick_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc && !last) begin
            count_d = count_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign last = (count_q == W'(LIMIT - 1));

endmodule

// File: rtl/recfg_req_latch.sv
module recfg_req_latch
    import recfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle,
    input  logic       req_reconfig,
    input  logic       req_image,
    input  logic       req_override,
    input  logic       req_capture,
    input  logic [1:0] req_reg_sel,
    output logic       accept,
    output logic       start_recfg,
    output logic       start_ovr,
    output seq_cmd_t   cmd_q
);
    seq_cmd_t cmd_d;

    always_comb begin
        cmd_d       = cmd_q;
        accept      = 1'b0;
        start_recfg = 1'b0;
        start_ovr   = 1'b0;
        if (idle) begin
            if (req_reconfig) begin
                accept        = 1'b1;
                start_recfg   = 1'b1;
                start_ovr     = req_override;
                cmd_d.kind    = CMD_RECFG;
                cmd_d.image   = req_image;
                cmd_d.reg_sel = 2'd0;
            end else if (req_capture) begin
                accept        = 1'b1;
                cmd_d.kind    = CMD_CAPTURE;
                cmd_d.image   = 1'b0;
                cmd_d.reg_sel = req_reg_sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{kind: CMD_NONE, image: 1'b0, reg_sel: 2'd0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    AST_ACCEPT_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        accept |-> idle) else $error("accept outside idle"); // R8
    AST_RECFG_WINS: assert property (@(posedge clk) disable iff (rst)
        (idle && req_reconfig && req_capture) |=> (cmd_q.kind == CMD_RECFG))
        else $error("capture won over reconfiguration"); // R8

endmodule

// File: rtl/recfg_seq_fsm.sv
module recfg_seq_fsm
    import recfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              start_recfg,
    input  logic              start_ovr,
    input  seq_cmd_t          cmd_q,
    input  logic              busy_bit,
    input  logic              gap_last,
    input  logic              poll_last,
    output logic              idle,
    output logic              gap_clr,
    output logic              gap_inc,
    output logic              poll_clr,
    output logic              poll_inc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_read,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        seq_state_e state;
        logic       done;
        logic       err;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        gap_inc  = 1'b0;
        poll_inc = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (start_recfg) begin
                        r_d.state = start_ovr ? ST_SEL_SET : ST_TRG_SET;
                    end else begin
                        r_d.state = ST_CAP_SET;
                    end
                end
            end
            ST_SEL_SET:  r_d.state = ST_SEL_STB;
            ST_SEL_STB:  r_d.state = ST_POLL_REQ;
            ST_CAP_SET:  r_d.state = ST_CAP_STB;
            ST_CAP_STB:  r_d.state = ST_POLL_REQ;
            ST_POLL_REQ: r_d.state = ST_POLL_SMP;
            ST_POLL_SMP: begin
                if (!busy_bit) begin
                    if (cmd_q.kind == CMD_RECFG) begin
                        r_d.state = ST_TRG_SET;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end
                end else begin
                    poll_inc = 1'b1;
                    if (poll_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                    end
                end
            end
            ST_TRG_SET:  r_d.state = ST_TRG_STB;
            ST_TRG_STB:  r_d.state = ST_QUIET;
            ST_QUIET: begin
                gap_inc = 1'b1;
                if (gap_last) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_addr  = '0;
        bus_write = 1'b0;
        bus_read  = 1'b0;
        bus_wdata = '0;
        unique case (r_q.state)
            ST_SEL_SET, ST_SEL_STB: begin
                bus_addr               = OFS_IMAGE;
                bus_wdata[SEL_OVR_BIT] = 1'b1;
                bus_wdata[SEL_IMG_BIT] = cmd_q.image;
                bus_write              = (r_q.state == ST_SEL_STB);
            end
            ST_TRG_SET, ST_TRG_STB: begin
                bus_addr     = OFS_TRIGGER;
                bus_wdata[0] = 1'b1;
                bus_write    = (r_q.state == ST_TRG_STB);
            end
            ST_CAP_SET, ST_CAP_STB: begin
                bus_addr  = OFS_CAPTURE;
                bus_wdata = DATA_W'(1) << cmd_q.reg_sel;
                bus_write = (r_q.state == ST_CAP_STB);
            end
            ST_POLL_REQ, ST_POLL_SMP: begin
                bus_addr = OFS_STATUS;
                bus_read = 1'b1;
            end
            default: ;
        endcase
    end

    assign idle     = (r_q.state == ST_IDLE);
    assign gap_clr  = (r_q.state != ST_QUIET);
    assign poll_clr = (r_q.state != ST_POLL_SMP);
    assign done     = r_q.done;
    assign err      = r_q.err;

    AST_POLL_HOLDS_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_POLL_SMP && busy_bit && !poll_last) |=> bus_read)
        else $error("poll dropped while busy"); // R3
    AST_NO_POLL_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_QUIET) |-> !bus_read && !bus_write)
        else $error("access inside quiet window"); // R5

endmodule

// File: rtl/recfg_cmd_seq.sv
module recfg_cmd_seq
    import recfg_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int GAP_CYCLES     = 3,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_reconfig,
    input  logic              req_image,
    input  logic              req_override,
    input  logic              req_capture,
    input  logic [1:0]        req_reg_sel,
    output logic              cmd_done,
    output logic              cmd_error,
    output logic [2:0]        reg_addr,
    output logic              reg_write,
    output logic              reg_read,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int GAP_EFF  = (GAP_CYCLES < 2) ? 2 : GAP_CYCLES;
    localparam int TOUT_EFF = (TIMEOUT_CYCLES < 1) ? 1 : TIMEOUT_CYCLES;

    logic     idle, accept, start_recfg, start_ovr;
    seq_cmd_t cmd_q;
    logic     gap_clr, gap_inc, gap_last;
    logic     poll_clr, poll_inc, poll_last;
    logic     unused_rdata_hi;

    assign unused_rdata_hi = ^reg_rdata[DATA_W-1:1];

    recfg_req_latch i_latch (
        .clk          (clk),
        .rst          (rst),
        .idle         (idle),
        .req_reconfig (req_reconfig),
        .req_image    (req_image),
        .req_override (req_override),
        .req_capture  (req_capture),
        .req_reg_sel  (req_reg_sel),
        .accept       (accept),
        .start_recfg  (start_recfg),
        .start_ovr    (start_ovr),
        .cmd_q        (cmd_q)
    );

    recfg_tick_cnt #(.LIMIT(GAP_EFF)) i_gap_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (gap_clr),
        .inc  (gap_inc),
        .last (gap_last)
    );

    recfg_tick_cnt #(.LIMIT(TOUT_EFF)) i_poll_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (poll_clr),
        .inc  (poll_inc),
        .last (poll_last)
    );

    recfg_seq_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .start_recfg (start_recfg),
        .start_ovr   (start_ovr),
        .cmd_q       (cmd_q),
        .busy_bit    (reg_rdata[0]),
        .gap_last    (gap_last),
        .poll_last   (poll_last),
        .idle        (idle),
        .gap_clr     (gap_clr),
        .gap_inc     (gap_inc),
        .poll_clr    (poll_clr),
        .poll_inc    (poll_inc),
        .bus_addr    (reg_addr),
        .bus_write   (reg_write),
        .bus_read    (reg_read),
        .bus_wdata   (reg_wdata),
        .done        (cmd_done),
        .err         (cmd_error)
    );

    AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(reg_write && reg_read)) else $error("read and write together"); // R10
    AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (rst)
        reg_write |-> (!$past(reg_write) && $past(reg_addr) == reg_addr
                       && $past(reg_wdata) == reg_wdata))
        else $error("write strobe without setup cycle"); // R10
    AST_QUIET_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (reg_write && reg_addr == OFS_TRIGGER) |=>
        (!reg_write && !reg_read && reg_addr == '0 && reg_wdata == '0))
        else $error("bus active right after trigger"); // R5
    AST_READ_AT_STATUS: assert property (@(posedge clk) disable iff (rst)
        reg_read |-> reg_addr == OFS_STATUS) else $error("read off status"); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done) else $error("done longer than a cycle"); // R7
    AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        cmd_error |-> cmd_done) else $error("error without done"); // R9

endmodule

// File: tb/test_recfg_cmd_seq.sv
module test_recfg_cmd_seq;
    localparam int DW   = 8;
    localparam int GAP  = 4;
    localparam int GAP2 = 2;  // GAP_CYCLES=1 raised to 2
    localparam int TOUT = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_reconfig = 1'b0, req_image = 1'b0, req_override = 1'b0;
    logic          req_capture = 1'b0;
    logic [1:0]    req_reg_sel = 2'd0;
    logic          cmd_done, cmd_error, done2, err2;
    logic [2:0]    reg_addr, addr2;
    logic          reg_write, reg_read, wr2, rd2;
    logic [DW-1:0] reg_wdata, wd2, reg_rdata;

    int   checks = 0;
    int   errors = 0;
    int   busy_len = 0;
    logic [7:0] busy_cnt;

    always #2 clk = ~clk;

    recfg_cmd_seq #(.DATA_W(DW), .GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TOUT)) i_recfg_cmd_seq (
        .clk(clk), .rst(rst), .req_reconfig(req_reconfig), .req_image(req_image),
        .req_override(req_override), .req_capture(req_capture), .req_reg_sel(req_reg_sel),
        .cmd_done(cmd_done), .cmd_error(cmd_error), .reg_addr(reg_addr),
        .reg_write(reg_write), .reg_read(reg_read), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    recfg_cmd_seq #(.DATA_W(DW), .GAP_CYCLES(1), .TIMEOUT_CYCLES(TOUT)) i_recfg_cmd_seq_g1 (
        .clk(clk), .rst(rst), .req_reconfig(req_reconfig), .req_image(req_image),
        .req_override(req_override), .req_capture(req_capture), .req_reg_sel(req_reg_sel),
        .cmd_done(done2), .cmd_error(err2), .reg_addr(addr2),
        .reg_write(wr2), .reg_read(rd2), .reg_wdata(wd2), .reg_rdata(reg_rdata)
    );

    // register stub: writes at image or capture offset start a busy window
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 8'd0;
        end else if (reg_write && (reg_addr == 3'd1 || reg_addr == 3'd2)) begin
            busy_cnt <= 8'(busy_len);
        end else if (busy_cnt != 8'd0) begin
            busy_cnt <= busy_cnt - 8'd1;
        end
    end
    assign reg_rdata = {{(DW-1){1'b0}}, busy_cnt != 8'd0};

    logic [2:0]    ea [32];
    logic          ew [32];
    logic          er [32];
    logic [DW-1:0] ed [32];
    string         et [32];
    int            n_exp;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic add(input int a, input bit w, input bit r, input int d, input string t);
        ea[n_exp] = 3'(a); ew[n_exp] = w; er[n_exp] = r; ed[n_exp] = DW'(d); et[n_exp] = t;
        n_exp++;
    endtask

    task automatic add_poll(input int b);
        int ns = (b < 1) ? 1 : b;
        add(3, 0, 1, 0, "R3");
        for (int j = 0; j < ns; j++) add(3, 0, 1, 0, "R3");
    endtask

    // kind: 0 reconfig, 1 capture; intrude: extra requests mid-command
    task automatic run(input int kind, input bit ovr, input bit img, input int idx,
                       input int b, input bit both, input bit intrude);
        bit tout;
        int d1, d2;
        n_exp = 0;
        busy_len = b;
        tout = (b > TOUT);
        if (kind == 0) begin
            if (ovr) begin
                add(1, 0, 0, 1 + 2 * img, "R2");
                add(1, 1, 0, 1 + 2 * img, "R2");
                add_poll(b);
            end
            if (!(ovr && tout)) begin
                add(0, 0, 0, 1, "R4");
                add(0, 1, 0, 1, "R4");
                for (int g = 0; g < GAP; g++) add(0, 0, 0, 0, "R5");
            end
        end else begin
            add(2, 0, 0, 1 << idx, "R6");
            add(2, 1, 0, 1 << idx, "R6");
            if (tout) begin
                add(3, 0, 1, 0, "R9");
                for (int j = 0; j < TOUT; j++) add(3, 0, 1, 0, "R9");
            end else begin
                add_poll(b);
            end
        end
        if (tout) begin
            n_exp = 0;
            if (kind == 0) begin
                add(1, 0, 0, 1 + 2 * img, "R9"); add(1, 1, 0, 1 + 2 * img, "R9");
            end else begin
                add(2, 0, 0, 1 << idx, "R9"); add(2, 1, 0, 1 << idx, "R9");
            end
            add(3, 0, 1, 0, "R9");
            for (int j = 0; j < TOUT; j++) add(3, 0, 1, 0, "R9");
        end
        add(0, 0, 0, 0, "R7");
        d1 = n_exp - 1;
        d2 = (kind == 0 && !tout) ? d1 - (GAP - GAP2) : d1;

        req_reconfig = (kind == 0) || both;
        req_capture  = (kind == 1) || both;
        req_override = ovr;
        req_image    = img;
        req_reg_sel  = 2'(idx);
        for (int i = 0; i < n_exp; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_reconfig = 1'b0; req_capture = 1'b0;
            end
            check({reg_addr, reg_write, reg_read, reg_wdata} == {ea[i], ew[i], er[i], ed[i]},
                  (intrude && i >= 2) ? "R8" : et[i], $sformatf("bus cycle %0d", i),
                  int'({reg_addr, reg_write, reg_read, reg_wdata}),
                  int'({ea[i], ew[i], er[i], ed[i]}));
            check(cmd_done == (i == d1), "R7", $sformatf("done cycle %0d", i),
                  int'(cmd_done), int'(i == d1));
            check(cmd_error == (tout && i == d1), "R9", $sformatf("error cycle %0d", i),
                  int'(cmd_error), int'(tout && i == d1));
            check(done2 == (i == d2), "R5", $sformatf("gap-clamped done cycle %0d", i),
                  int'(done2), int'(i == d2));
            if (intrude) begin
                req_reconfig = (i == 1);
                req_capture  = (i == 1);
                req_override = 1'b1;
                req_reg_sel  = 2'(3 - idx);
            end
        end
        req_reconfig = 1'b0; req_capture = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({reg_addr, reg_write, reg_read, reg_wdata, cmd_done, cmd_error} == '0, "R1",
              "reset outputs", int'({reg_addr, reg_write, reg_read, reg_wdata}), 0);

        for (int o = 0; o < 2; o++)
            for (int m = 0; m < 2; m++)
                for (int b = 0; b < 4; b++)
                    run(0, o[0], m[0], 0, b, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 4; b++)
                run(1, 1'b0, 1'b0, k, b, 1'b0, 1'b0);

        run(0, 1'b0, 1'b1, 2, 0, 1'b1, 1'b0);  // R8: both requests, reconfig wins
        run(0, 1'b1, 1'b0, 0, 3, 1'b1, 1'b0);
        run(1, 1'b0, 1'b0, 1, 3, 1'b0, 1'b1);  // R8: mid-command requests ignored
        run(0, 1'b1, 1'b1, 0, 2, 1'b0, 1'b1);
        run(1, 1'b0, 1'b0, 3, TOUT + 5, 1'b0, 1'b0);  // R9 timeout
        run(0, 1'b1, 1'b0, 0, TOUT + 5, 1'b0, 1'b0);

        // R1: reset in the middle of a poll
        busy_len = 3;
        req_capture = 1'b1; req_reg_sel = 2'd2;
        @(negedge clk); req_capture = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check({reg_addr, reg_write, reg_read, reg_wdata, cmd_done, cmd_error} == '0, "R1",
              "outputs after mid-command reset", int'({reg_addr, reg_write, reg_read}), 0);
        @(negedge clk);
        check({reg_addr, reg_write, reg_read} == '0 && !cmd_done, "R1",
              "stays idle after reset", int'({reg_addr, reg_write, reg_read}), 0);
        run(1, 1'b0, 1'b0, 0, 1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule